// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps a processor core's notion of elapsed time. It holds a 64-bit time base that counts up and two 32-bit down-counters: a supervisor decrementer and a hypervisor decrementer. All three counters advance on a shared tick enable. The time base counts only while a run input is high. While the run input is low, the time base holds its value and then resumes from that value. Software reads and writes every counter through a small synchronous register port. The time base is reached as two 32-bit halves.

Each decrementer drives an interrupt line from its own pending flag. A mode input selects one of three behaviours, which differ in when the flag is set and when it clears:
- **Edge mode:** the interrupt follows the most significant bit turning on, and a delivery acknowledge clears it.
- **Level mode:** the interrupt follows the most significant bit as a level and clears only on a write.
- **Stop-at-zero mode:** the count saturates at zero rather than running negative.

The hypervisor decrementer also has a power-managed input. While it is high, expiries of that decrementer are thrown away.

Top module: `tbdec_unit`

## Requirements
- R1: A write to register address 0 replaces time base bits 31:0 and keeps bits 63:32. A write to address 1 replaces bits 63:32 and keeps bits 31:0. A read of address 0 or 1 returns the matching half. A read of address 2 returns the supervisor decrementer, and a read of address 3 returns the hypervisor decrementer.
- R2: The time base adds one per cycle when both tickEn and tbRun are high. With tbRun low it holds exactly, and when tbRun returns high it continues from the held value.
- R3: In edge mode (decMode=0, and 3 acts the same) and level mode (decMode=1), a tick taking a decrementer from 0 to all ones sets its interrupt. No other tick raises it. A tick from 0x80000000 to 0x7FFFFFFF does not raise it.
- R4: In level mode, the interrupt is set by a write with bit 31 set or by an underflow. It is cleared only by a write with bit 31 clear, and that clear wins over any raise in the same write. Acknowledge has no effect.
- R5: In edge and stop modes, a write that turns bit 31 from 0 to 1 raises the interrupt at once. A write of a negative value over an already negative count does not raise it.
- R6: A write of 0 or 1 raises the interrupt at once in edge and stop modes.
- R7: In edge and stop modes, the interrupt stays set until its acknowledge input (ackDec or ackHdec) is high at a clock edge. A raise in the same cycle as an acknowledge wins.
- R8: In stop mode (decMode=2), a tick from 1 to 0 raises the interrupt. A count of 0 then stays 0 on later ticks, with no further raise.
- R9: After reset, the time base is 0, both decrementers are 0xFFFFFFFF and both interrupts are low.
- R10: While pmState is high, every raise of the hypervisor decrementer interrupt is discarded, whether it comes from a tick or from a write. The supervisor decrementer ignores pmState.
- R11: A register write in the same cycle as a tick loads the written value, and the tick has no effect on that counter in that cycle. Interrupt outputs change on the clock edge after the event that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Shared count enable for all counters |
| tbRun | input | 1 | Time base run; low freezes the time base |
| decMode | input | 2 | 0 edge, 1 level, 2 stop-at-zero, 3 as edge |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 tb low, 1 tb high, 2 dec, 3 hdec |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| ackDec | input | 1 | Delivery acknowledge, supervisor decrementer |
| ackHdec | input | 1 | Delivery acknowledge, hypervisor decrementer |
| pmState | input | 1 | Power-managed state; discards hypervisor expiries |
| decIrq | output | 1 | Supervisor decrementer interrupt |
| hdecIrq | output | 1 | Hypervisor decrementer interrupt |

## Verification
A wrong count value appears on the read port in the same cycle the bad register edge occurs. A bad pending flag shows on the interrupt pins one edge after the event that set it wrongly. For this reason, the reference model is compared against both pins and the selected read value at every falling edge. Sticky pending state is the slow case: a raise that was wrongly dropped stays hidden until the next acknowledge or write would have changed the pin. The stimulus therefore acknowledges and rewrites right after each expiry.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;

  typedef enum logic [1:0] {
    MODE_EDGE  = 2'd0,
    MODE_LEVEL = 2'd1,
    MODE_STOP  = 2'd2,
    MODE_ALT   = 2'd3
  } decMode_e;

  localparam logic [1:0] ADDR_TB_LO = 2'd0;
  localparam logic [1:0] ADDR_TB_HI = 2'd1;
  localparam logic [1:0] ADDR_DEC   = 2'd2;
  localparam logic [1:0] ADDR_HDEC  = 2'd3;

  localparam int N_DEC = 2;

  typedef struct packed {
    logic             tbLoWr;
    logic             tbHiWr;
    logic             tbStep;
    logic [N_DEC-1:0] decWr;
    logic             decStep;
    logic             modeLevel;
    logic             modeStop;
  } strobe_t;

endpackage

// File: rtl/tbdec_ctrl.sv
module tbdec_ctrl
  import tbdec_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       tickEn,
  input  logic       tbRun,
  input  logic [1:0] decMode,
  output strobe_t    strb
);

  decMode_e modeSel;

  always_comb begin
    modeSel        = decMode_e'(decMode);
    strb           = '0;
    strb.tbLoWr    = regWrEn && (regAddr == ADDR_TB_LO);
    strb.tbHiWr    = regWrEn && (regAddr == ADDR_TB_HI);
    strb.tbStep    = tickEn && tbRun;
    strb.decWr[0]  = regWrEn && (regAddr == ADDR_DEC);
    strb.decWr[1]  = regWrEn && (regAddr == ADDR_HDEC);
    strb.decStep   = tickEn;
    strb.modeLevel = (modeSel == MODE_LEVEL);
    strb.modeStop  = (modeSel == MODE_STOP);
  end

endmodule

// File: rtl/tbdec_chan.sv
module tbdec_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wr,
  input  logic [W-1:0] wrData,
  input  logic         step,
  input  logic         modeLevel,
  input  logic         modeStop,
  input  logic         ack,
  input  logic         suppress,
  output logic [W-1:0] count,
  output logic         pend
);

  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = W'(1);

  logic cntZero, cntOne, stepEvent, wrRaise, raise, levelLower, ackLower;
  logic [W-1:0] nextCnt;

  always_comb begin
    cntZero    = (count == '0);
    cntOne     = (count == ONE);
    stepEvent  = step && !wr && (modeStop ? cntOne : cntZero);
    wrRaise    = wr && ((wrData <= ONE) ||
                        (wrData[MSB] && (modeLevel || !count[MSB])));
    raise      = (stepEvent || wrRaise) && !suppress;
    levelLower = modeLevel && wr && !wrData[MSB];
    ackLower   = !modeLevel && ack;
    if (wr)                       nextCnt = wrData;
    else if (step && modeStop && cntZero) nextCnt = count;
    else if (step)                nextCnt = count - ONE;
    else                          nextCnt = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '1;
      pend  <= 1'b0;
    end else begin
      count <= nextCnt;
      if (levelLower)    pend <= 1'b0;
      else if (raise)    pend <= 1'b1;
      else if (ackLower) pend <= 1'b0;
    end
  end

  AST_UNDERFLOW_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (step && !wr && cntZero && !modeStop && !suppress) |=> pend); // R3

  AST_LEVEL_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (modeLevel && wr && !wrData[MSB]) |=> !pend); // R4

  AST_STOP_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (modeStop && step && !wr && cntZero) |=> (count == '0)); // R8

  AST_SUPPRESS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (suppress && !pend) |=> !pend); // R10

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wr |=> (count == $past(wrData))); // R11

endmodule

// File: rtl/tbdec_datapath.sv
module tbdec_datapath
  import tbdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [N_DEC-1:0]  ackIn,
  input  logic [N_DEC-1:0]  suppressIn,
  output logic [DATA_W-1:0] regRdData,
  output logic [N_DEC-1:0]  irqOut
);

  localparam int TB_W = 2 * DATA_W;

  logic [TB_W-1:0]   tbReg;
  logic [DATA_W-1:0] decCnt [N_DEC];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbReg <= '0;
    end else if (strb.tbLoWr) begin
      tbReg[DATA_W-1:0] <= regWrData;
    end else if (strb.tbHiWr) begin
      tbReg[TB_W-1:DATA_W] <= regWrData;
    end else if (strb.tbStep) begin
      tbReg <= tbReg + TB_W'(1);
    end
  end

  for (genvar g = 0; g < N_DEC; g++) begin : g_chan
    tbdec_chan #(.W(DATA_W)) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .wr        (strb.decWr[g]),
      .wrData    (regWrData),
      .step      (strb.decStep),
      .modeLevel (strb.modeLevel),
      .modeStop  (strb.modeStop),
      .ack       (ackIn[g]),
      .suppress  (suppressIn[g]),
      .count     (decCnt[g]),
      .pend      (irqOut[g])
    );
  end

  always_comb begin
    case (regAddr)
      ADDR_TB_LO: regRdData = tbReg[DATA_W-1:0];
      ADDR_TB_HI: regRdData = tbReg[TB_W-1:DATA_W];
      ADDR_DEC:   regRdData = decCnt[0];
      default:    regRdData = decCnt[1];
    endcase
  end

  AST_TB_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tbStep && !strb.tbLoWr && !strb.tbHiWr) |=> $stable(tbReg)); // R2

  AST_TB_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
    strb.tbLoWr |=> (tbReg[TB_W-1:DATA_W] == $past(tbReg[TB_W-1:DATA_W]))); // R1

  AST_TB_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
    strb.tbHiWr |=> (tbReg[DATA_W-1:0] == $past(tbReg[DATA_W-1:0]))); // R1

endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
  import tbdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              tbRun,
  input  logic [1:0]        decMode,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              ackDec,
  input  logic              ackHdec,
  input  logic              pmState,
  output logic              decIrq,
  output logic              hdecIrq
);

  strobe_t          strb;
  logic [N_DEC-1:0] irqVec;

  tbdec_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .tickEn  (tickEn),
    .tbRun   (tbRun),
    .decMode (decMode),
    .strb    (strb)
  );

  tbdec_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .ackIn      ({ackHdec, ackDec}),
    .suppressIn ({pmState, 1'b0}),
    .regRdData  (regRdData),
    .irqOut     (irqVec)
  );

  assign decIrq  = irqVec[0];
  assign hdecIrq = irqVec[1];

endmodule

// File: tb/tbdec_unit_tb.sv
module tbdec_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        tbRun = 1'b1;
  logic [1:0]  decMode = 2'd0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        ackDec = 1'b0;
  logic        ackHdec = 1'b0;
  logic        pmState = 1'b0;
  logic        decIrq, hdecIrq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curReq = "R9";
  bit modelValid = 1'b0;
  bit done = 1'b0;

  logic [63:0] mTb;
  logic [31:0] mCnt [2];
  bit          mPend [2];

  always #5 clk = ~clk;

  tbdec_unit u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .tbRun(tbRun), .decMode(decMode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ackDec(ackDec), .ackHdec(ackHdec),
    .pmState(pmState), .decIrq(decIrq), .hdecIrq(hdecIrq)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mTb = 64'd0;
      mCnt[0] = 32'hFFFF_FFFF; mCnt[1] = 32'hFFFF_FFFF;
      mPend[0] = 0; mPend[1] = 0;
    end else begin
      if (regWrEn && regAddr == 2'd0)      mTb = {mTb[63:32], regWrData};
      else if (regWrEn && regAddr == 2'd1) mTb = {regWrData, mTb[31:0]};
      else if (tickEn && tbRun)            mTb = mTb + 64'd1;
      for (int ch = 0; ch < 2; ch++) begin
        bit lvl, stp, w, ev, ak;
        logic [31:0] old;
        lvl = (decMode == 2'd1);
        stp = (decMode == 2'd2);
        w   = regWrEn && (regAddr == 2'(ch + 2));
        ak  = (ch == 0) ? ackDec : ackHdec;
        old = mCnt[ch];
        ev  = 0;
        if (w) begin
          if (regWrData < 32'd2) ev = 1;
          if (regWrData[31] && (lvl || !old[31])) ev = 1;
          mCnt[ch] = regWrData;
        end else if (tickEn) begin
          if (stp) begin
            if (old == 32'd1) ev = 1;
            if (old != 32'd0) mCnt[ch] = old - 32'd1;
          end else begin
            if (old == 32'd0) ev = 1;
            mCnt[ch] = old - 32'd1;
          end
        end
        if (ch == 1 && pmState) ev = 0;
        if (lvl && w && !regWrData[31]) mPend[ch] = 0;
        else if (ev)                    mPend[ch] = 1;
        else if (!lvl && ak)            mPend[ch] = 0;
      end
    end
    modelValid = 1'b1;
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelValid && !done) begin
      logic [31:0] expRd;
      case (regAddr)
        2'd0: expRd = mTb[31:0];
        2'd1: expRd = mTb[63:32];
        2'd2: expRd = mCnt[0];
        default: expRd = mCnt[1];
      endcase
      check("read", regRdData, expRd);
      check("decIrq", {31'd0, decIrq}, {31'd0, mPend[0]});
      check("hdecIrq", {31'd0, hdecIrq}, {31'd0, mPend[1]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
    regWrEn = 1'b0; ackDec = 1'b0; ackHdec = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    cyc(1);
  endtask

  initial begin
    // R9: reset state
    curReq = "R9";
    cyc(3);
    rstN = 1'b1;
    regAddr = 2'd2; cyc(1);
    regAddr = 2'd3; cyc(1);
    regAddr = 2'd0; cyc(1);

    // R1: half writes, carry from low into high
    curReq = "R1";
    wr(2'd0, 32'hFFFF_FFF0);
    wr(2'd1, 32'h1234_5678);
    tickEn = 1'b1; tbRun = 1'b1;
    for (int i = 0; i < 20; i++) begin regAddr = 2'(i % 2); cyc(1); end
    wr(2'd0, 32'h0000_00AA); regAddr = 2'd1; cyc(1);
    wr(2'd1, 32'h0000_0001); regAddr = 2'd0; cyc(1);

    // R2: freeze and resume
    curReq = "R2";
    tbRun = 1'b0; cyc(6);
    tbRun = 1'b1; cyc(4);

    // R3: underflow in edge mode, and no event at the sign boundary
    curReq = "R3";
    decMode = 2'd0; tickEn = 1'b0;
    wr(2'd2, 32'd3); regAddr = 2'd2;
    tickEn = 1'b1; cyc(6);
    ackDec = 1'b1; cyc(1);
    tickEn = 1'b0; wr(2'd2, 32'h8000_0000);
    ackDec = 1'b1; cyc(1);
    tickEn = 1'b1; cyc(3);

    // R5: write turning the sign bit on raises; already negative does not
    curReq = "R5";
    tickEn = 1'b0;
    wr(2'd2, 32'h0000_0007);
    wr(2'd2, 32'h8000_0005); cyc(1);
    ackDec = 1'b1; cyc(1);
    wr(2'd2, 32'h8000_0009); cyc(2);

    // R6: small writes raise at once
    curReq = "R6";
    wr(2'd2, 32'h0000_0000); cyc(1);
    ackDec = 1'b1; wr(2'd2, 32'h0000_0040); cyc(1);
    wr(2'd2, 32'h0000_0001); cyc(1);

    // R7: acknowledge clears; raise beats simultaneous acknowledge
    curReq = "R7";
    ackDec = 1'b1; cyc(1);
    wr(2'd2, 32'd1); tickEn = 1'b1; cyc(1);
    ackDec = 1'b1; cyc(1);
    cyc(2);
    tickEn = 1'b0; ackDec = 1'b1; cyc(1);

    // R4: level mode
    curReq = "R4";
    decMode = 2'd1;
    wr(2'd2, 32'h8000_0000); cyc(1);
    ackDec = 1'b1; cyc(2);
    wr(2'd2, 32'h0000_0010); cyc(1);
    wr(2'd2, 32'd2); tickEn = 1'b1; cyc(5);
    tickEn = 1'b0;
    wr(2'd2, 32'd0); cyc(2);

    // R8: stop-at-zero mode
    curReq = "R8";
    decMode = 2'd2;
    wr(2'd2, 32'd3); tickEn = 1'b1; cyc(7);
    ackDec = 1'b1; cyc(3);

    // R10: hypervisor expiries discarded while power-managed
    curReq = "R10";
    decMode = 2'd0; tickEn = 1'b0; pmState = 1'b1;
    wr(2'd3, 32'd2); regAddr = 2'd3;
    tickEn = 1'b1; cyc(5);
    tickEn = 1'b0;
    wr(2'd3, 32'd0); cyc(1);
    wr(2'd2, 32'd0); regAddr = 2'd3; cyc(1);
    pmState = 1'b0;
    wr(2'd3, 32'd1); cyc(1);
    ackHdec = 1'b1; ackDec = 1'b1; cyc(1);

    // R11: write beats tick in the same cycle
    curReq = "R11";
    tickEn = 1'b1;
    wr(2'd3, 32'h0000_0100); regAddr = 2'd3; cyc(2);
    wr(2'd0, 32'h0000_0050); regAddr = 2'd0; cyc(2);
    tickEn = 1'b0;

    // mixed traffic across all modes
    curReq = "R3";
    for (int i = 0; i < 600; i++) begin
      tickEn    = 1'($urandom_range(0, 3) != 0);
      tbRun     = 1'($urandom_range(0, 4) != 0);
      decMode   = 2'($urandom_range(0, 3));
      pmState   = 1'($urandom_range(0, 1));
      regAddr   = 2'($urandom_range(0, 3));
      regWrEn   = 1'($urandom_range(0, 5) == 0);
      regWrData = ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 4))
                                              : $urandom;
      ackDec    = 1'($urandom_range(0, 3) == 0);
      ackHdec   = 1'($urandom_range(0, 3) == 0);
      @(posedge clk); #2;
    end
    regWrEn = 1'b0; ackDec = 1'b0; ackHdec = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule